// File: doc/BRIEF.md
# Counting Stream Register Snoop Filter

This block sits beside a local cache and decides, for each incoming snoop, whether the cache needs to be looked up at all. It keeps a small bank of stream registers. Each one describes a set of line addresses with a base address and a mask of the bits that are still significant. Between them the registers always describe a superset of the lines the cache may hold. A snoop that no occupied register covers is filtered, because the line cannot be in the cache. Any other snoop is forwarded to the cache.

Every line fill goes into exactly one register. If the fill address differs from that register's base on some significant bits, those bits become don't-care, so the register's coverage only ever grows. Each register also has an occupancy counter in place of a plain valid bit. Fills increment it and evictions decrement it. When the count returns to zero the register is empty again and can be reused, so no flush of the whole bank is needed. The line address width, the number of registers and the counter width are parameters. A synchronous flush input empties every register.

Top module: `stream_snoop_filter`

## Requirements
- R1: After reset, every register is empty, `resp_valid` is low, and every snoop is filtered (`resp_forward` = 0).
- R2: A snoop presented with `snoop_valid` at a clock edge produces `resp_valid` = 1 on the next cycle. In that cycle `resp_forward` is 1 exactly when some occupied register has a base equal to the snoop address on every bit its mask keeps significant (mask bit 1 = significant).
- R3: When a fill lands in an empty register, that register's base is set to the fill address and its mask to all ones. A later snoop to the fill address is forwarded, and a snoop to a neighbouring address that no register covers is filtered.
- R4: Each fill updates exactly one register. The choice is made in this order: the lowest-index empty register; if none is empty, the register whose mask would lose the fewest significant bits; among equal losses, the lowest index.
- R5: A fill into an occupied register clears every mask bit where the fill address differs from the base. Snoops to any address matching on the remaining bits, including lines never filled, are then forwarded.
- R6: An eviction whose address is covered by exactly one occupied register decrements that register's counter by one. When the counter reaches zero, the register filters every snoop.
- R7: An eviction whose address is covered by two or more occupied registers changes no counter.
- R8: A counter that has reached its maximum (all ones) holds that value. Later fills and evictions leave it unchanged, so the register stays occupied until a flush.
- R9: A fill and a snoop in the same cycle are resolved fill first, so a snoop to the line being filled is forwarded.
- R10: A synchronous flush empties every register, including saturated ones. A snoop in the same cycle as a flush is filtered.
- R11: An eviction whose address no occupied register covers has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of all registers |
| fill_valid | input | 1 | Cache loads a line this cycle |
| fill_line | input | ADDR_W | Line address being loaded |
| evict_valid | input | 1 | Cache evicts or invalidates a line this cycle |
| evict_line | input | ADDR_W | Line address leaving the cache |
| snoop_valid | input | 1 | Snoop request present |
| snoop_line | input | ADDR_W | Line address of the snoop |
| resp_valid | output | 1 | Decision for the snoop of the previous cycle |
| resp_forward | output | 1 | 1 = forward to the cache, 0 = filtered |

## Verification
The hardest situation to reach from the ports is an eviction that two occupied registers both cover. An address only becomes doubly covered after one register's mask has widened over it and a later fill has put the same line into a freshly emptied register. The stimulus builds this on purpose. It first fills all registers, then widens one with a near address and a tied-cost fill, empties another with evictions, and refills it with an address inside the widened range. Repeated ambiguous evictions would then drain the widened register if they were wrongly applied, and snoops to lines that only that register covers show whether it was.

// File: rtl/ssf_pkg.sv
// Package: shared definitions for the counting stream register snoop filter.
// Assumes nothing beyond IEEE 1800-2017.
package ssf_pkg;

    // Decision returned for one snoop.
    typedef enum logic {
        SNP_FILTER  = 1'b0,
        SNP_FORWARD = 1'b1
    } snp_dec_e;

endpackage

// File: rtl/ssf_stream_reg.sv
// Module: one stream register (base, significance mask, occupancy counter).
// It reports its emptiness, the mask cost of a candidate fill and whether it
// covers the eviction address. It also reports whether its post-update state
// covers the snoop address, which gives the fill-first ordering.
// Assumes: load and drop are never set while the register is empty at the same time as drop.
module ssf_stream_reg #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3,
    parameter int CW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [ADDR_W-1:0] fill_line,
    input  logic              drop,
    input  logic [ADDR_W-1:0] evict_line,
    input  logic [ADDR_W-1:0] snoop_line,
    output logic              is_empty,
    output logic [CW-1:0]     fill_cost,
    output logic              evict_cover,
    output logic              snoop_hit
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [ADDR_W-1:0] base_q, mask_q, base_d, mask_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // Combinational status seen by the selector and the eviction logic.
    always_comb begin
        is_empty    = (cnt_q == '0);
        fill_cost   = CW'($countones((fill_line ^ base_q) & mask_q));
        evict_cover = !is_empty && (((evict_line ^ base_q) & mask_q) == '0);
    end

    // Next-state computation: flush, then fill widening, then counting.
    always_comb begin
        base_d = base_q;
        mask_d = mask_q;
        cnt_d  = cnt_q;
        if (flush) begin
            base_d = '0;
            mask_d = '0;
            cnt_d  = '0;
        end else begin
            if (load) begin
                if (cnt_q == '0) begin
                    base_d = fill_line;
                    mask_d = '1;
                end else begin
                    mask_d = mask_q & ~(fill_line ^ base_q);
                end
            end
            if (cnt_q != CMAX) begin
                if (load && !drop)
                    cnt_d = cnt_q + 1'b1;
                else if (!load && drop)
                    cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // Snoop coverage evaluated on the state after this cycle's updates.
    always_comb begin
        snoop_hit = (cnt_d != '0) && (((snoop_line ^ base_d) & mask_d) == '0);
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            mask_q <= mask_d;
            cnt_q  <= cnt_d;
        end
    end

    // R5: an occupied register's mask never regains significant bits.
    p_mask_only_widens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !flush) |=> ((mask_q & ~$past(mask_q)) == '0));

    // R8: a saturated counter stays saturated until a flush.
    p_sat_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX && !flush) |=> (cnt_q == CMAX));

    // R3: after a fill the register is occupied and covers the filled line.
    p_fill_covered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> (cnt_q != '0) && ((($past(fill_line) ^ base_q) & mask_q) == '0));

    // R6: a lone decrement lowers an unsaturated count by exactly one.
    p_drop_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !load && !flush && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R10: flush leaves the register empty.
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));

endmodule

// File: rtl/ssf_fill_pick.sv
// Module: chooses the register that receives a fill.
// Lowest-index empty register first; otherwise the smallest mask cost,
// with ties going to the lowest index. Output is one-hot.
// Assumes: N >= 1; costs are packed register 0 in the low slice.
module ssf_fill_pick #(
    parameter int N  = 4,
    parameter int CW = 5
) (
    input  logic [N-1:0]    empty_vec,
    input  logic [N*CW-1:0] cost_flat,
    output logic [N-1:0]    pick
);
    // Priority search over empty registers, then over mask cost.
    always_comb begin
        logic          found;
        int            best;
        logic [CW-1:0] best_cost;
        pick      = '0;
        found     = 1'b0;
        best      = 0;
        best_cost = cost_flat[CW-1:0];
        for (int i = 0; i < N; i++) begin
            if (!found && empty_vec[i]) begin
                found = 1'b1;
                best  = i;
            end
        end
        if (!found) begin
            for (int i = 1; i < N; i++) begin
                if (cost_flat[i*CW +: CW] < best_cost) begin
                    best_cost = cost_flat[i*CW +: CW];
                    best      = i;
                end
            end
        end
        pick[best] = 1'b1;
    end
endmodule

// File: rtl/stream_snoop_filter.sv
// Module: top of the counting stream register snoop filter.
// Routes each fill to one register. Applies an eviction only when exactly one
// occupied register covers it. Registers a forward/filter decision one cycle
// after each snoop. Assumes evictions name lines that were previously filled.
module stream_snoop_filter #(
    parameter int ADDR_W = 16,
    parameter int NUM_REG = 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_line,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_line,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_line,
    output logic              resp_valid,
    output logic              resp_forward
);
    import ssf_pkg::*;

    localparam int CW = $clog2(ADDR_W + 1);

    logic [NUM_REG-1:0]    empty_vec, pick, cover_vec, hit_vec, drop_vec, load_vec;
    logic [NUM_REG*CW-1:0] cost_flat;
    logic                  single_cover;
    snp_dec_e              dec_d;

    ssf_fill_pick #(.N(NUM_REG), .CW(CW)) u_pick (
        .empty_vec (empty_vec),
        .cost_flat (cost_flat),
        .pick      (pick)
    );

    // Eviction is applied only when its owner is unambiguous.
    always_comb begin
        single_cover = (cover_vec != '0) && ((cover_vec & (cover_vec - 1'b1)) == '0);
        drop_vec     = (evict_valid && single_cover) ? cover_vec : '0;
        load_vec     = fill_valid ? pick : '0;
        dec_d        = (snoop_valid && (|hit_vec)) ? SNP_FORWARD : SNP_FILTER;
    end

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        logic [CW-1:0] cost_g;
        ssf_stream_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CW(CW)) u_sr (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush       (flush),
            .load        (load_vec[g]),
            .fill_line   (fill_line),
            .drop        (drop_vec[g]),
            .evict_line  (evict_line),
            .snoop_line  (snoop_line),
            .is_empty    (empty_vec[g]),
            .fill_cost   (cost_g),
            .evict_cover (cover_vec[g]),
            .snoop_hit   (hit_vec[g])
        );
        assign cost_flat[g*CW +: CW] = cost_g;
    end

    // Registered snoop decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_forward <= 1'b0;
        end else begin
            resp_valid   <= snoop_valid;
            resp_forward <= (dec_d == SNP_FORWARD);
        end
    end

    // R4: a fill selects exactly one register.
    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $onehot(pick));

    // R2: a response follows each snoop one cycle later, and only then.
    p_resp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |=> resp_valid);
    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid |=> !resp_valid);

    // R7: an ambiguous eviction decrements nothing.
    p_ambiguous_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && $countones(cover_vec) > 1) |-> (drop_vec == '0));

    // R10: a snoop during a flush is filtered.
    p_flush_filters_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && snoop_valid) |=> !resp_forward);

endmodule

// File: tb/stream_snoop_filter_test.sv
// Scoreboard bench: driver tasks queue the expected decision of each snoop,
// and a monitor pops and compares the decisions as they appear.
module stream_snoop_filter_test;
    localparam int  ADDR_W = 16;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_line = '0;
    logic              evict_valid = 1'b0;
    logic [ADDR_W-1:0] evict_line = '0;
    logic              snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_line = '0;
    logic              resp_valid, resp_forward;

    int    n_checks = 0;
    int    n_fails = 0;
    bit    done = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    stream_snoop_filter #(.ADDR_W(ADDR_W), .NUM_REG(4), .CNT_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fill_valid(fill_valid), .fill_line(fill_line),
        .evict_valid(evict_valid), .evict_line(evict_line),
        .snoop_valid(snoop_valid), .snoop_line(snoop_line),
        .resp_valid(resp_valid), .resp_forward(resp_forward)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: compare each decision against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R2: response with no pending snoop, actual fwd=%0b expected none", resp_forward);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (resp_forward !== e) begin
                    n_fails++;
                    $display("FAIL %s: actual fwd=%0b expected %0b", t, resp_forward, e);
                end
            end
        end
    end

    // Each task starts at a falling edge and ends at the next one.
    task automatic step();
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0; evict_valid = 1'b0; snoop_valid = 1'b0;
    endtask

    task automatic fill(input logic [ADDR_W-1:0] a);
        fill_valid = 1'b1; fill_line = a; step();
    endtask

    task automatic evict(input logic [ADDR_W-1:0] a);
        evict_valid = 1'b1; evict_line = a; step();
    endtask

    task automatic snoop(input logic [ADDR_W-1:0] a, input bit e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        snoop_valid = 1'b1; snoop_line = a; step();
    endtask

    task automatic fill_and_snoop(input logic [ADDR_W-1:0] a, input bit e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        fill_valid = 1'b1; fill_line = a;
        snoop_valid = 1'b1; snoop_line = a; step();
    endtask

    task automatic flush_and_snoop(input logic [ADDR_W-1:0] a, input bit e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        flush = 1'b1; snoop_valid = 1'b1; snoop_line = a; step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run is counted as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (resp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: actual resp_valid=%0b expected 0", resp_valid);
        end
        snoop(16'h0000, 1'b0, "R1");
        snoop(16'h1234, 1'b0, "R1");

        fill(16'h1000);                        // register 0, empty realloc
        snoop(16'h1000, 1'b1, "R3");
        snoop(16'h1001, 1'b0, "R3");
        fill_and_snoop(16'h2000, 1'b1, "R9");  // register 1
        fill(16'h4000);                        // register 2
        fill(16'h8000);                        // register 3
        fill(16'h1003);                        // cost 2 on reg 0, 4 elsewhere
        snoop(16'h1001, 1'b1, "R5");
        snoop(16'h1002, 1'b1, "R5");
        snoop(16'h1004, 1'b0, "R5");
        fill(16'h3000);                        // tie at cost 1: reg 0 wins
        snoop(16'h3002, 1'b1, "R4");

        evict(16'h8000);
        snoop(16'h8000, 1'b0, "R6");
        evict(16'h4000);
        snoop(16'h4000, 1'b0, "R6");
        evict(16'h2001);                       // covered by nobody
        snoop(16'h2000, 1'b1, "R11");

        fill(16'h3001);                        // empty reg 2, overlaps reg 0
        for (int k = 0; k < 3; k++) evict(16'h3001);
        snoop(16'h1002, 1'b1, "R7");
        snoop(16'h3001, 1'b1, "R7");

        flush_and_snoop(16'h1000, 1'b0, "R10");
        snoop(16'h2000, 1'b0, "R10");

        fill(16'h6000); fill(16'hA000); fill(16'hC000); fill(16'hE000);
        for (int k = 0; k < 7; k++) fill(16'h6000);
        snoop(16'h6000, 1'b1, "R8");
        for (int k = 0; k < 10; k++) evict(16'h6000);
        snoop(16'h6000, 1'b1, "R8");

        fill(16'hA000);                        // reg 1 count becomes 2
        evict(16'hA000);
        snoop(16'hA000, 1'b1, "R6");
        evict(16'hA000);
        snoop(16'hA000, 1'b0, "R6");

        flush_and_snoop(16'h0000, 1'b0, "R10");
        snoop(16'h6000, 1'b0, "R10");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R2: actual %0d responses missing expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule